// File: doc/BRIEF.md
# Diagonal Lane Reduce-Scatter Unit

This block combines partial results held by four processing lanes, each lane standing in for one separate compute unit. Lane `a` owns a row of four signed 8-bit values, one for each output index `b`. The reduction runs along `a`, and the result is scattered so that lane `i` ends up holding only the total for output index `i`: the sum of element `i` across every lane's row.

One start pulse loads the whole 4x4 operand array in parallel. The block then runs one phase per clock. In phase `k`, each lane picks one element from its row along a shifted diagonal. The picked values are then rotated cyclically across the lanes. The add stage works only on these pre-arranged operands: it adds each one into that lane's wide accumulator. After the fourth phase, a single-cycle done pulse marks the per-lane sums as final. The sums stay on the outputs until the next accepted start.

Top module: `diag_reduce_scatter`

## Requirements
- R1: Operand element (row `a`, index `b`) is a two's-complement byte at `data_in[(a*4+b)*8 +: 8]`. The 10-bit signed sum of lane `i` is at `sum_out[i*10 +: 10]`.
- R2: When done is high, lane `i` shows the exact signed sum of elements (a, i) for a = 0..3. This holds with no overflow across the full range, from -512 to +508.
- R3: `data_in` is sampled only at the clock edge that accepts a start. Changing it afterwards does not change the result.
- R4: `done` is high for exactly one cycle. It rises at the fourth rising clock edge after the accepting edge, and the final sums appear at that same edge.
- R5: A start sampled while an operation is in progress (at any of the four edges after the accepting edge) is ignored. The running operation keeps its timing and its data.
- R6: The accepting edge clears every lane sum to zero.
- R7: The phases run in order. At the edge k+1 after acceptance, lane `i` holds the sum of elements ((i+j) mod 4, i) for j = 0..k. The first edge therefore leaves the diagonal element (i, i).
- R8: When idle, the sums hold their values. A start may be accepted at the edge right after done rises, while done is still high.
- R9: An active-low `rst_n` clears the sums and `done` at once, whatever the clock is doing, and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a new reduction; sampled at rising edges |
| data_in | input | 128 | 4x4 array of signed bytes, row-major by lane |
| sum_out | output | 40 | Four 10-bit signed lane sums |
| done | output | 1 | One-cycle pulse when sums are final |

## Verification
Diagonal and rotation mistakes hide easily, because the final totals are the same for many wrong index orders. For that reason the stimulus uses operand arrays whose entries are all distinct, and it checks the partial sums phase by phase, not only the final totals. The hardest states to reach are a start arriving mid-operation and a start landing on the very cycle that done is high. The bench drives the first with a forked process that holds start high, with different data, during the busy edges. It drives the second by issuing the next start in the cycle immediately after a completion. The range limits are reached with arrays of all -128 and all +127.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
   localparam int DEF_LANES  = 4;
   localparam int DEF_ELEM_W = 8;

   // Width needed to add LANES signed values of ELEM_W bits without overflow
   function automatic int acc_width(input int elem_w, input int lanes);
      return elem_w + $clog2(lanes);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/rsd_ctrl.sv
module rsd_ctrl #(
   parameter int LANES = rsd_pkg::DEF_LANES,
   localparam int PW   = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [PW-1:0] phase,
   output logic          capture,
   output logic          add_en,
   output logic          done
);
   localparam logic [PW-1:0] LAST_PHASE = PW'(LANES - 1);

   assign capture = start & ~busy;
   assign add_en  = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         phase <= '0;
         done  <= 1'b0;
      end else begin
         done <= busy && (phase == LAST_PHASE);
         if (capture) begin
            busy  <= 1'b1;
            phase <= '0;
         end else if (busy) begin
            phase <= phase + 1'b1;
            if (phase == LAST_PHASE) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rsd_diag_select.sv
module rsd_diag_select #(
   parameter int LANES   = rsd_pkg::DEF_LANES,
   parameter int ELEM_W  = rsd_pkg::DEF_ELEM_W,
   parameter int LANE_ID = 0,
   localparam int PW     = $clog2(LANES)
) (
   input  logic [LANES*ELEM_W-1:0] row,
   input  logic [PW-1:0]           phase,
   output logic [ELEM_W-1:0]       elem
);
   logic [PW-1:0] col;

   // Index (LANE_ID - phase) mod LANES; LANES is a power of two
   assign col  = PW'(LANE_ID) - phase;
   assign elem = row[col*ELEM_W +: ELEM_W];
endmodule

// File: rtl/rsd_lane_rotate.sv
module rsd_lane_rotate #(
   parameter int LANES  = rsd_pkg::DEF_LANES,
   parameter int ELEM_W = rsd_pkg::DEF_ELEM_W,
   localparam int PW    = $clog2(LANES)
) (
   input  logic [LANES*ELEM_W-1:0] picked,
   input  logic [PW-1:0]           phase,
   output logic [LANES*ELEM_W-1:0] rotated
);
   for (genvar i = 0; i < LANES; i++) begin : g_dst
      logic [PW-1:0] src;
      assign src = PW'(i) + phase;
      assign rotated[i*ELEM_W +: ELEM_W] = picked[src*ELEM_W +: ELEM_W];
   end
endmodule

// File: rtl/rsd_lane_accum.sv
module rsd_lane_accum #(
   parameter int ELEM_W = rsd_pkg::DEF_ELEM_W,
   parameter int ACC_W  = rsd_pkg::acc_width(ELEM_W, rsd_pkg::DEF_LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [ELEM_W-1:0] operand,
   output logic [ACC_W-1:0]  acc
);
   logic [ACC_W-1:0] operand_ext;

   assign operand_ext = {{(ACC_W-ELEM_W){operand[ELEM_W-1]}}, operand};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc + operand_ext;
   end
endmodule

// File: rtl/diag_reduce_scatter.sv
module diag_reduce_scatter #(
   parameter int LANES  = rsd_pkg::DEF_LANES,
   parameter int ELEM_W = rsd_pkg::DEF_ELEM_W,
   parameter int ACC_W  = rsd_pkg::acc_width(ELEM_W, LANES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [LANES*LANES*ELEM_W-1:0] data_in,
   output logic [LANES*ACC_W-1:0]        sum_out,
   output logic                          done
);
   localparam int PW    = $clog2(LANES);
   localparam int ROW_W = LANES * ELEM_W;

   if (!rsd_pkg::is_pow2(LANES)) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (ACC_W < rsd_pkg::acc_width(ELEM_W, LANES)) begin : g_bad_acc
      $error("ACC_W too narrow to hold the lane sum");
   end

   logic          busy;
   logic [PW-1:0] phase;
   logic          capture;
   logic          add_en;

   logic [LANES*ROW_W-1:0]  rows_q;
   logic [ROW_W-1:0]        picked;
   logic [ROW_W-1:0]        rotated;

   rsd_ctrl #(.LANES(LANES)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .busy    (busy),
      .phase   (phase),
      .capture (capture),
      .add_en  (add_en),
      .done    (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rows_q <= '0;
      else if (capture) rows_q <= data_in;
   end

   for (genvar c = 0; c < LANES; c++) begin : g_lane
      rsd_diag_select #(
         .LANES   (LANES),
         .ELEM_W  (ELEM_W),
         .LANE_ID (c)
      ) u_sel (
         .row   (rows_q[c*ROW_W +: ROW_W]),
         .phase (phase),
         .elem  (picked[c*ELEM_W +: ELEM_W])
      );

      rsd_lane_accum #(
         .ELEM_W (ELEM_W),
         .ACC_W  (ACC_W)
      ) u_acc (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (capture),
         .en      (add_en),
         .operand (rotated[c*ELEM_W +: ELEM_W]),
         .acc     (sum_out[c*ACC_W +: ACC_W])
      );
   end

   rsd_lane_rotate #(
      .LANES  (LANES),
      .ELEM_W (ELEM_W)
   ) u_rot (
      .picked  (picked),
      .phase   (phase),
      .rotated (rotated)
   );
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
   parameter int LANES = rsd_pkg::DEF_LANES,
   parameter int SUM_W = 40,
   localparam int PW   = $clog2(LANES),
   localparam int CW   = $clog2(LANES) + 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic [PW-1:0]    phase,
   input logic             done,
   input logic [SUM_W-1:0] sum_out
);
   localparam logic [PW-1:0] LAST_PHASE = PW'(LANES - 1);

   logic [CW-1:0] since_go;
   logic          tracking;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_go <= '0;
         tracking <= 1'b0;
      end else if (start && !busy) begin
         since_go <= '0;
         tracking <= 1'b1;
      end else if (tracking && (since_go != {CW{1'b1}})) begin
         since_go <= since_go + 1'b1;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tracking && since_go == CW'(LANES))); // R4

   AST_CLEAR_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (sum_out == '0)); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(sum_out)); // R8

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase != LAST_PHASE) |=> (busy && phase == PW'($past(phase) + 1'b1))); // R7

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && phase != LAST_PHASE) |=> (phase != '0)); // R5
endmodule

bind diag_reduce_scatter rsd_checker #(
   .LANES (LANES),
   .SUM_W (LANES*ACC_W)
) u_rsd_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .phase   (phase),
   .done    (done),
   .sum_out (sum_out)
);

// File: tb/diag_reduce_scatter_tb_top.sv
module diag_reduce_scatter_tb_top;
   localparam int L  = 4;
   localparam int EW = 8;
   localparam int AW = 10;

   logic              clk;
   logic              rst_n;
   logic              start;
   logic [L*L*EW-1:0] data_in;
   logic [L*AW-1:0]   sum_out;
   logic              done;

   int n_checks;
   int n_fails;
   int ev [L][L];   // expected operand array [row a][index b]

   diag_reduce_scatter dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .data_in (data_in),
      .sum_out (sum_out),
      .done    (done)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int lane_sum(input int i);
      return int'($signed(sum_out[i*AW +: AW]));
   endfunction

   function automatic logic [L*L*EW-1:0] pack_ev();
      logic [L*L*EW-1:0] v = '0;
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++)
            v[(a*L+b)*EW +: EW] = EW'(ev[a][b]);
      return v;
   endfunction

   function automatic int partial(input int i, input int k);
      int s = 0;
      for (int j = 0; j <= k; j++) s += ev[(i+j)%L][i];
      return s;
   endfunction

   // Called at a falling edge: presents start and operands, returns at the falling edge after acceptance
   task automatic launch();
      data_in = pack_ev();
      start   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start   = 1'b0;
   endtask

   // Called at the falling edge after acceptance; returns at the falling edge after done rises
   task automatic follow_run(input string tag);
      for (int i = 0; i < L; i++) chk({tag, " R6 cleared"}, lane_sum(i), 0);
      chk({tag, " R4 done low"}, int'(done), 0);
      for (int k = 0; k < L; k++) begin
         @(negedge clk);
         if (k < L-1) begin
            chk({tag, " R4 done low mid"}, int'(done), 0);
            for (int i = 0; i < L; i++) chk({tag, " R7 partial"}, lane_sum(i), partial(i, k));
         end
      end
      chk({tag, " R4 done high"}, int'(done), 1);
      for (int i = 0; i < L; i++) chk({tag, " R2 final sum"}, lane_sum(i), partial(i, L-1));
   endtask

   task automatic t_reset();
      for (int i = 0; i < L; i++) chk("R9 reset sum", lane_sum(i), 0);
      chk("R9 reset done", int'(done), 0);
   endtask

   task automatic t_basic();
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = a*10 + b + 1;
      launch();
      follow_run("basic");
      @(negedge clk);
      chk("R4 done one cycle", int'(done), 0);
      for (int i = 0; i < L; i++) chk("R1 lane field", lane_sum(i), 4*i + 64);
      repeat (3) @(negedge clk);
      for (int i = 0; i < L; i++) chk("R8 idle hold", lane_sum(i), partial(i, L-1));
   endtask

   task automatic t_signed_mix();
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = ((a*37 + b*53 + 11) % 256) - 128;
      launch();
      follow_run("mix");
      @(negedge clk);
   endtask

   task automatic t_extremes();
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = -128;
      launch();
      follow_run("min");
      for (int i = 0; i < L; i++) chk("R2 minimum", lane_sum(i), -512);
      @(negedge clk);
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = 127;
      launch();
      follow_run("max");
      for (int i = 0; i < L; i++) chk("R2 maximum", lane_sum(i), 508);
      @(negedge clk);
   endtask

   task automatic t_start_while_busy();
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = (a == b) ? -100 + a : a - 3*b;
      launch();
      fork
         follow_run("R5 busy start");
         begin
            data_in = ~pack_ev();
            start   = 1'b1;
            repeat (3) @(negedge clk);
            start   = 1'b0;
         end
      join
      @(negedge clk);
      chk("R5 no restart", int'(done), 0);
      for (int i = 0; i < L; i++) chk("R5 result kept", lane_sum(i), partial(i, L-1));
   endtask

   task automatic t_data_change();
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = 5*b - 7*a;
      launch();
      fork
         follow_run("R3 data change");
         begin
            for (int n = 0; n < L; n++) begin
               data_in = {L*L{8'(n*29 + 3)}};
               @(negedge clk);
            end
         end
      join
      @(negedge clk);
   endtask

   task automatic t_back_to_back();
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = a + 2*b;
      launch();
      follow_run("b2b first");
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = -(a*16 + b*3) - 1;
      launch();
      follow_run("R8 b2b second");
      @(negedge clk);
   endtask

   task automatic t_async_reset();
      int seen = 0;
      for (int a = 0; a < L; a++)
         for (int b = 0; b < L; b++) ev[a][b] = 50 + a - b;
      launch();
      @(negedge clk);
      #3 rst_n = 1'b0;
      #1;
      for (int i = 0; i < L; i++) chk("R9 async clear", lane_sum(i), 0);
      chk("R9 async done", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         seen += int'(done);
      end
      chk("R9 run abandoned", seen, 0);
   endtask

   initial begin
      #4_000_000;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      n_checks = 0;
      n_fails  = 0;
      rst_n    = 1'b0;
      start    = 1'b0;
      data_in  = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_signed_mix();
      t_extremes();
      t_start_while_busy();
      t_data_change();
      t_back_to_back();
      t_async_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule